// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synthesizable behavioural model of a small pipelined synchronous SRAM with burst addressing. Each word is 36 bits wide, split into four lanes of 9 bits: 8 data bits and 1 parity bit. Lane `i` occupies bits `[9i+8:9i]`. Address, control and write data are captured on the rising clock edge. A write lands in the array on the following edge, and read data comes back through an output register.

An access starts on one of two active-low strobes. `req_rd_n` always starts a read and wins when both strobes are low. `req_rw_n` starts a read or a write, depending on the write controls. After a start, a 2-bit burst sequencer steps the low address bits while `burst_adv_n` is low. The order is linear or interleaved. When no strobe is present and `burst_adv_n` is high, the burst holds its address and repeats the access. Writes can touch any subset of the four lanes. A global write input forces all four lanes.

The data output drive is gated by an asynchronous output enable. A sleep mode freezes all activity while keeping the array contents. Sleep can only be entered once no burst is active. After sleep is left, there is a two-cycle recovery window.

Top module: `burst_sram`

## Requirements
- R1: While `rst_n` is low, and after its release until the first read completes, `rdata_oe` is low.
- R2: An access starts at the edge where a strobe is sampled low with `sel_n` low. For a read, `rdata` holds the addressed word and `rdata_oe` is high after the next rising edge, and not before it.
- R3: A start on `req_rd_n` is always a read and never changes the array, even when the write controls are active or `req_rw_n` is also low.
- R4: A write happens when `all_wr_n` is high, `lane_wen_n` is low and `lane_sel_n` has at least one bit low. Only lane `i` with `lane_sel_n[i]` low (bits `[9i+8:9i]`) is written. The other lanes keep their contents.
- R5: When `all_wr_n` is low, every lane is written, whatever `lane_wen_n` and `lane_sel_n` are.
- R6: While `lane_wen_n` and `all_wr_n` are high, `lane_sel_n` has no effect: a `req_rw_n` start is a read.
- R7: A read of an address issued in the cycle right after a write to that address returns the newly written data.
- R8: Each edge with `burst_adv_n` low during an active burst, and no strobe, moves to the next beat. The address low two bits are `(base+k) mod 4` when `burst_linear` is 1, and `base XOR k` when it is 0. The upper address bits stay fixed. Reads and writes both follow this order.
- R9: An edge with no strobe and `burst_adv_n` high during an active burst repeats the access at the current beat address.
- R10: `out_en_n` high forces `rdata_oe` low with no clock edge. Dropping it restores the drive with unchanged `rdata`.
- R11: A strobe sampled with `sel_n` high ends the burst. `rdata_oe` is low from the second edge after it, and later `burst_adv_n` pulses start nothing.
- R12: With `sleep_req` high, sleep is entered at the first edge where no burst is active and no strobe is present. While asleep, `rdata_oe` is low, all strobes are ignored and the array contents are kept.
- R13: Strobes at the edge where sleep is left (`sleep_req` sampled low) and at the two edges after it are ignored. The next strobe is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | Request for the low-power sleep state |
| sel_n | input | 1 | Chip select, active low, sampled with a strobe |
| req_rd_n | input | 1 | Start strobe that always reads |
| req_rw_n | input | 1 | Start strobe, read or write per write controls |
| burst_adv_n | input | 1 | Advance to next burst beat when low |
| burst_linear | input | 1 | 1: linear burst order, 0: interleaved |
| addr | input | 8 | Word address |
| all_wr_n | input | 1 | Global write of all lanes, active low |
| lane_wen_n | input | 1 | Enables the per-lane write selects, active low |
| lane_sel_n | input | 4 | Per-lane write selects, active low |
| wdata | input | 36 | Write data, four 9-bit lanes |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | 36 | Registered read data |
| rdata_oe | output | 1 | Output drive enable; low means the data pins float |

## Verification
The bench works through the places where the lane masks can go wrong. A per-lane write must leave the lanes it did not select intact. A global write must not be masked by the lane selects. A `req_rd_n` start with write controls active must not slip through as a write. Bursts are run from a base whose low bits are 1, so that the linear order (1,2,3,0) and the interleaved order (1,0,3,2) both differ from each other and from a plain counter; a wrong wrap or a missed step shows up as the wrong word. The sleep checks cover three failures: a design that sleeps in the middle of a burst drops the output drive; one that lets sleep-time strobes through, or uses a recovery window shorter than two cycles, overwrites a word that must survive; and one whose window is too long rejects the first legal read.

// File: rtl/sram_pkg.sv
package sram_pkg;
  // Operation carried by the first pipeline stage.
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;
endpackage

// File: rtl/burst_seq.sv
module burst_seq #(
  parameter int BW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [BW-1:0] base_in,
  input  logic          linear,
  output logic [BW-1:0] cur_lo,
  output logic [BW-1:0] nxt_lo
);
  logic [BW-1:0] base_q;
  logic [BW-1:0] cnt_q, cnt_d, cnt_n1;

  assign cnt_n1 = cnt_q + BW'(1);

  always_comb begin
    cnt_d = cnt_q;
    if (load)      cnt_d = '0;
    else if (step) cnt_d = cnt_n1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_ff @(posedge clk) begin
    if (load) base_q <= base_in;
  end

  assign cur_lo = linear ? (base_q + cnt_q)  : (base_q ^ cnt_q);
  assign nxt_lo = linear ? (base_q + cnt_n1) : (base_q ^ cnt_n1);
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_pkg::*;
#(
  parameter int AW       = 8,
  parameter int BW       = 2,
  parameter int LANES    = 4,
  parameter int WORD_W   = 36,
  parameter int WAKE_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_req,
  input  logic              sel_n,
  input  logic              req_rd_n,
  input  logic              req_rw_n,
  input  logic              burst_adv_n,
  input  logic [AW-1:0]     addr,
  input  logic              all_wr_n,
  input  logic              lane_wen_n,
  input  logic [LANES-1:0]  lane_sel_n,
  input  logic [WORD_W-1:0] wdata,
  input  logic [BW-1:0]     cur_lo,
  input  logic [BW-1:0]     nxt_lo,
  output logic              seq_load,
  output logic              seq_step,
  output op_e               s1_op,
  output logic [AW-1:0]     s1_addr,
  output logic [WORD_W-1:0] s1_data,
  output logic [LANES-1:0]  s1_mask,
  output logic              busy,
  output logic              asleep
);
  localparam int WK_W = $clog2(WAKE_CYC + 1);

  logic            busy_q, busy_d;
  logic            asleep_q, asleep_d;
  logic [WK_W-1:0] wake_q, wake_d;
  logic [AW-BW-1:0] hi_q;
  op_e             op_d;
  logic [AW-1:0]   addr_d;
  logic            gate, start, wr_req;
  logic [LANES-1:0] mask;

  assign gate   = asleep_q || (wake_q != '0);
  assign start  = !gate && (!req_rd_n || !req_rw_n);
  assign wr_req = !all_wr_n || (!lane_wen_n && (lane_sel_n != '1));
  assign mask   = !all_wr_n ? '1 : (!lane_wen_n ? ~lane_sel_n : '0);

  // Access decode: strobe start, burst continuation or suspend.
  always_comb begin
    op_d     = OP_NONE;
    busy_d   = busy_q;
    addr_d   = s1_addr;
    seq_load = 1'b0;
    seq_step = 1'b0;
    if (start) begin
      if (sel_n) begin
        busy_d = 1'b0;
      end else begin
        busy_d   = 1'b1;
        seq_load = 1'b1;
        addr_d   = addr;
        op_d     = (!req_rd_n || !wr_req) ? OP_RD : OP_WR;
      end
    end else if (!gate && busy_q) begin
      if (!burst_adv_n) begin
        seq_step = 1'b1;
        addr_d   = {hi_q, nxt_lo};
      end else begin
        addr_d   = {hi_q, cur_lo};
      end
      op_d = wr_req ? OP_WR : OP_RD;
    end
  end

  // Sleep entry and recovery window.
  always_comb begin
    asleep_d = asleep_q;
    wake_d   = wake_q;
    if (asleep_q) begin
      if (!sleep_req) begin
        asleep_d = 1'b0;
        wake_d   = WK_W'(WAKE_CYC);
      end
    end else if (wake_q != '0) begin
      wake_d = wake_q - WK_W'(1);
    end else if (sleep_req && !busy_q && !start) begin
      asleep_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_op    <= OP_NONE;
      busy_q   <= 1'b0;
      asleep_q <= 1'b0;
      wake_q   <= '0;
    end else begin
      s1_op    <= op_d;
      busy_q   <= busy_d;
      asleep_q <= asleep_d;
      wake_q   <= wake_d;
    end
  end

  always_ff @(posedge clk) begin
    if (!gate) begin
      s1_addr <= addr_d;
      s1_data <= wdata;
      s1_mask <= mask;
    end
    if (seq_load) hi_q <= addr[AW-1:BW];
  end

  assign busy   = busy_q;
  assign asleep = asleep_q;
endmodule

// File: rtl/sram_array.sv
module sram_array
  import sram_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int AW     = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  op_e               op,
  input  logic [AW-1:0]     addr,
  input  logic [WORD_W-1:0] data,
  input  logic [LANES-1:0]  mask,
  output logic [WORD_W-1:0] rdata,
  output logic              rvalid
);
  logic [WORD_W-1:0] rd_word;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (op == OP_WR && mask[g]) mem[addr] <= data[g*LANE_W +: LANE_W];
    end
    assign rd_word[g*LANE_W +: LANE_W] = mem[addr];
  end

  always_ff @(posedge clk) begin
    if (op == OP_RD) rdata <= rd_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rvalid <= 1'b0;
    else        rvalid <= (op == OP_RD);
  end
endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import sram_pkg::*;
#(
  parameter int DEPTH    = 256,
  parameter int LANES    = 4,
  parameter int LANE_W   = 9,
  parameter int BURST_W  = 2,
  parameter int WAKE_CYC = 2,
  localparam int AW      = $clog2(DEPTH),
  localparam int WORD_W  = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_req,
  input  logic              sel_n,
  input  logic              req_rd_n,
  input  logic              req_rw_n,
  input  logic              burst_adv_n,
  input  logic              burst_linear,
  input  logic [AW-1:0]     addr,
  input  logic              all_wr_n,
  input  logic              lane_wen_n,
  input  logic [LANES-1:0]  lane_sel_n,
  input  logic [WORD_W-1:0] wdata,
  input  logic              out_en_n,
  output logic [WORD_W-1:0] rdata,
  output logic              rdata_oe
);
  logic [BURST_W-1:0] cur_lo, nxt_lo;
  logic               seq_load, seq_step, busy, asleep, rvalid;
  op_e                s1_op;
  logic [AW-1:0]      s1_addr;
  logic [WORD_W-1:0]  s1_data;
  logic [LANES-1:0]   s1_mask;

  burst_seq #(.BW(BURST_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .load(seq_load), .step(seq_step),
    .base_in(addr[BURST_W-1:0]), .linear(burst_linear),
    .cur_lo(cur_lo), .nxt_lo(nxt_lo)
  );

  sram_ctrl #(
    .AW(AW), .BW(BURST_W), .LANES(LANES), .WORD_W(WORD_W), .WAKE_CYC(WAKE_CYC)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .sel_n(sel_n),
    .req_rd_n(req_rd_n), .req_rw_n(req_rw_n), .burst_adv_n(burst_adv_n),
    .addr(addr), .all_wr_n(all_wr_n), .lane_wen_n(lane_wen_n),
    .lane_sel_n(lane_sel_n), .wdata(wdata), .cur_lo(cur_lo), .nxt_lo(nxt_lo),
    .seq_load(seq_load), .seq_step(seq_step), .s1_op(s1_op),
    .s1_addr(s1_addr), .s1_data(s1_data), .s1_mask(s1_mask),
    .busy(busy), .asleep(asleep)
  );

  sram_array #(
    .DEPTH(DEPTH), .AW(AW), .LANES(LANES), .LANE_W(LANE_W)
  ) u_arr (
    .clk(clk), .rst_n(rst_n), .op(s1_op), .addr(s1_addr), .data(s1_data),
    .mask(s1_mask), .rdata(rdata), .rvalid(rvalid)
  );

  // Output drive: asynchronous enable, forced off while asleep.
  assign rdata_oe = rvalid && !out_en_n && !asleep;
endmodule

// File: rtl/sram_chk.sv
module sram_chk
  import sram_pkg::*;
#(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             out_en_n,
  input logic             sel_n,
  input logic             req_rd_n,
  input logic             req_rw_n,
  input logic             all_wr_n,
  input logic             rdata_oe,
  input logic             asleep,
  input logic             busy,
  input op_e              s1_op,
  input logic [LANES-1:0] s1_mask
);
  p_oe_float_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> !rdata_oe);

  p_read_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_op == OP_RD) |=> (rdata_oe || out_en_n));

  p_rd_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_rd_n && !sel_n) |=> (s1_op != OP_WR));

  p_global_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!all_wr_n && !sel_n && !req_rw_n && req_rd_n && !asleep)
      |=> (s1_op == OP_NONE || s1_mask == '1));

  p_sleep_float_r12: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> !rdata_oe);

  p_sleep_entry_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep) |-> !$past(busy));

  p_sleep_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |=> (s1_op == OP_NONE));

  p_wake_window_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(asleep) |-> (s1_op == OP_NONE) ##1 (s1_op == OP_NONE) ##1 (s1_op == OP_NONE));
endmodule

bind burst_sram sram_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_en_n(out_en_n), .sel_n(sel_n),
  .req_rd_n(req_rd_n), .req_rw_n(req_rw_n), .all_wr_n(all_wr_n),
  .rdata_oe(rdata_oe), .asleep(asleep), .busy(busy),
  .s1_op(s1_op), .s1_mask(s1_mask)
);

// File: tb/burst_sram_tb.sv
module burst_sram_tb;
  localparam int DEPTH = 256;
  localparam int AW    = 8;
  localparam int W     = 36;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sleep_req, sel_n, req_rd_n, req_rw_n, burst_adv_n, burst_linear;
  logic [AW-1:0] addr;
  logic          all_wr_n, lane_wen_n, out_en_n;
  logic [3:0]    lane_sel_n;
  logic [W-1:0]  wdata, rdata;
  logic          rdata_oe;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] sh [DEPTH];

  always #4 clk = ~clk;

  burst_sram u_dut (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .sel_n(sel_n),
    .req_rd_n(req_rd_n), .req_rw_n(req_rw_n), .burst_adv_n(burst_adv_n),
    .burst_linear(burst_linear), .addr(addr), .all_wr_n(all_wr_n),
    .lane_wen_n(lane_wen_n), .lane_sel_n(lane_sel_n), .wdata(wdata),
    .out_en_n(out_en_n), .rdata(rdata), .rdata_oe(rdata_oe)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    sel_n = 1'b0; req_rd_n = 1'b1; req_rw_n = 1'b1; burst_adv_n = 1'b1;
    all_wr_n = 1'b1; lane_wen_n = 1'b1; lane_sel_n = 4'hF;
  endtask

  task automatic deselect();
    idle();
    req_rw_n = 1'b0; sel_n = 1'b1;
    tick();
    idle();
  endtask

  function automatic logic [W-1:0] merge(input logic [W-1:0] old, input logic [W-1:0] nw,
                                         input logic [3:0] m);
    logic [W-1:0] r = old;
    for (int i = 0; i < 4; i++) if (m[i]) r[i*9 +: 9] = nw[i*9 +: 9];
    return r;
  endfunction

  // Write started on req_rw_n; shadow follows R4/R5/R6.
  task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] d, input logic gwn,
                    input logic bwen, input logic [3:0] bwn);
    logic [3:0] m;
    idle();
    req_rw_n = 1'b0; addr = a; wdata = d; all_wr_n = gwn; lane_wen_n = bwen; lane_sel_n = bwn;
    tick();
    deselect();
    m = !gwn ? 4'hF : (!bwen ? ~bwn : 4'h0);
    sh[a] = merge(sh[a], d, m);
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [W-1:0] d, output logic oe);
    idle();
    req_rd_n = 1'b0; addr = a;
    tick();
    deselect();
    d = rdata; oe = rdata_oe;
    tick();
  endtask

  task automatic t_reset();
    chk(rdata_oe == 1'b0, "R1 reset drive", W'(rdata_oe), '0);
    rst_n = 1'b1;
    tick();
    chk(rdata_oe == 1'b0, "R1 after reset", W'(rdata_oe), '0);
  endtask

  task automatic t_read_latency();
    wr(8'h10, 36'h1_2345_6789, 1'b0, 1'b1, 4'hF);
    idle(); req_rd_n = 1'b0; addr = 8'h10;
    tick();
    chk(rdata_oe == 1'b0, "R2 not before second edge", W'(rdata_oe), '0);
    deselect();
    chk(rdata_oe == 1'b1, "R2 drive", W'(rdata_oe), 1);
    chk(rdata == sh[8'h10], "R2 data", rdata, sh[8'h10]);
    // R10: asynchronous output enable
    out_en_n = 1'b1; #1;
    chk(rdata_oe == 1'b0, "R10 float", W'(rdata_oe), '0);
    out_en_n = 1'b0; #1;
    chk(rdata_oe == 1'b1 && rdata == sh[8'h10], "R10 restore", rdata, sh[8'h10]);
    tick();
  endtask

  task automatic t_lanes();
    logic [W-1:0] d; logic oe;
    wr(8'h11, 36'hF_FFFF_FFFF, 1'b0, 1'b1, 4'hF);
    wr(8'h11, 36'h0_0000_0000, 1'b1, 1'b0, 4'b1010);
    rd(8'h11, d, oe);
    chk(d == sh[8'h11], "R4 lanes 0 and 2 only", d, sh[8'h11]);
    wr(8'h12, 36'h0_0000_0000, 1'b0, 1'b1, 4'hF);
    wr(8'h12, 36'hA_BCDE_F012, 1'b0, 1'b0, 4'b1110);
    rd(8'h12, d, oe);
    chk(d == 36'hA_BCDE_F012, "R5 global write all lanes", d, 36'hA_BCDE_F012);
    wr(8'h13, 36'h5_5555_5555, 1'b0, 1'b1, 4'hF);
    idle(); req_rw_n = 1'b0; addr = 8'h13; wdata = 36'h0; lane_sel_n = 4'h0;
    tick();
    deselect();
    chk(rdata_oe && rdata == 36'h5_5555_5555, "R6 selects ignored, read", rdata, 36'h5_5555_5555);
    tick();
    rd(8'h13, d, oe);
    chk(d == 36'h5_5555_5555, "R6 array unchanged", d, 36'h5_5555_5555);
  endtask

  task automatic t_rd_strobe();
    logic [W-1:0] d; logic oe;
    wr(8'h14, 36'h3_3333_3333, 1'b0, 1'b1, 4'hF);
    idle(); req_rd_n = 1'b0; req_rw_n = 1'b0; addr = 8'h14; wdata = 36'h0; all_wr_n = 1'b0;
    tick();
    deselect();
    tick();
    rd(8'h14, d, oe);
    chk(d == 36'h3_3333_3333, "R3 read strobe never writes", d, 36'h3_3333_3333);
  endtask

  task automatic t_pass();
    idle(); req_rw_n = 1'b0; addr = 8'h15; wdata = 36'h9_8765_4321; all_wr_n = 1'b0;
    tick();
    idle(); req_rd_n = 1'b0; addr = 8'h15;
    tick();
    deselect();
    sh[8'h15] = 36'h9_8765_4321;
    chk(rdata_oe && rdata == 36'h9_8765_4321, "R7 pass-through", rdata, 36'h9_8765_4321);
    tick();
  endtask

  task automatic t_burst(input logic lin);
    logic [AW-1:0] a;
    burst_linear = lin;
    idle(); req_rd_n = 1'b0; addr = 8'h21;
    tick();
    idle(); burst_adv_n = 1'b0;
    for (int k = 0; k < 4; k++) begin
      tick();
      a = {6'h08, lin ? 2'(2'd1 + 2'(k)) : (2'd1 ^ 2'(k))};
      chk(rdata_oe && rdata == sh[a], "R8 burst read beat", rdata, sh[a]);
    end
    deselect();
    tick();
  endtask

  task automatic t_burst_write();
    logic [W-1:0] d; logic oe;
    burst_linear = 1'b1;
    idle(); req_rw_n = 1'b0; addr = 8'h31; all_wr_n = 1'b0; wdata = 36'h1_0000_0001;
    tick();
    idle(); burst_adv_n = 1'b0; all_wr_n = 1'b0;
    for (int k = 1; k < 4; k++) begin
      wdata = 36'h1_0000_0001 + W'(k);
      tick();
    end
    deselect();
    for (int k = 0; k < 4; k++) begin
      rd({6'h0C, 2'(2'd1 + 2'(k))}, d, oe);
      chk(d == 36'h1_0000_0001 + W'(k), "R8 burst write order", d, 36'h1_0000_0001 + W'(k));
    end
  endtask

  task automatic t_suspend();
    burst_linear = 1'b1;
    idle(); req_rd_n = 1'b0; addr = 8'h21;
    tick();
    idle(); burst_adv_n = 1'b0;
    tick();
    idle();
    tick();
    tick();
    chk(rdata_oe && rdata == sh[8'h22], "R9 suspend repeats beat", rdata, sh[8'h22]);
    burst_adv_n = 1'b0;
    tick();
    tick();
    chk(rdata_oe && rdata == sh[8'h23], "R9 resume after suspend", rdata, sh[8'h23]);
    deselect();
    tick();
  endtask

  task automatic t_deselect();
    idle(); req_rd_n = 1'b0; addr = 8'h20;
    tick();
    idle();
    tick();
    deselect();
    chk(rdata_oe == 1'b1, "R11 drive holds one edge", W'(rdata_oe), 1);
    burst_adv_n = 1'b0;
    tick();
    chk(rdata_oe == 1'b0, "R11 float after deselect", W'(rdata_oe), '0);
    tick();
    chk(rdata_oe == 1'b0, "R11 advance starts nothing", W'(rdata_oe), '0);
    idle();
  endtask

  task automatic t_sleep();
    logic [W-1:0] d; logic oe;
    wr(8'h40, 36'h7_7777_7777, 1'b0, 1'b1, 4'hF);
    idle(); req_rd_n = 1'b0; addr = 8'h40;
    tick();
    idle(); sleep_req = 1'b1;
    tick();
    tick();
    chk(rdata_oe == 1'b1, "R12 no sleep during burst", W'(rdata_oe), 1);
    deselect();
    tick();
    chk(rdata_oe == 1'b0, "R12 asleep floats", W'(rdata_oe), '0);
    req_rw_n = 1'b0; addr = 8'h40; all_wr_n = 1'b0; wdata = 36'h0_1111_1111;
    tick();
    tick();
    sleep_req = 1'b0; wdata = 36'h0_2222_2222;
    tick();
    tick();
    tick();
    idle();
    rd(8'h40, d, oe);
    chk(oe == 1'b1, "R13 access accepted after window", W'(oe), 1);
    chk(d == 36'h7_7777_7777, "R12 R13 strobes ignored, array kept", d, 36'h7_7777_7777);
  endtask

  initial begin
    sleep_req = 1'b0; out_en_n = 1'b0; burst_linear = 1'b1; addr = '0; wdata = '0;
    idle();
    for (int i = 0; i < DEPTH; i++) sh[i] = '0;
    repeat (3) @(posedge clk);
    #2;
    t_reset();
    for (int i = 0; i < 4; i++) wr(8'h20 + 8'(i), 36'h8_0000_0000 + W'(i * 17), 1'b0, 1'b1, 4'hF);
    t_read_latency();
    t_lanes();
    t_rd_strobe();
    t_pass();
    t_burst(1'b1);
    t_burst(1'b0);
    t_burst_write();
    t_suspend();
    t_deselect();
    t_sleep();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule